// File: doc/BRIEF.md
# Interrupt Request Latch and Dispatcher

This block accepts a bank of external interrupt request lines. Each line is set up on its own as edge- or level-sensitive, and as active-high or active-low. Once a request is seen, the block latches it. It then issues a delivery message that carries the line number, an 8-bit vector and a destination processor number. The line stays latched until an end-of-interrupt notice names it.

Messages leave on a valid/ready handshake, and only one is outstanding at a time. The receiver confirms each accepted message on a separate acknowledge input. If that confirmation does not arrive within a fixed window, the same message is issued again. Pending lines are served lowest index first. Software sets the block up through two registers: an index register that selects an entry, and a data register that reaches the selected entry.

Top module: `irq_router`

## Requirements
- R1: `reg_sel_i`=0 reaches the index register and `reg_sel_i`=1 reaches the entry it selects; reads are combinational on `reg_rdata_o`. Indices 0..7 are line entries. Each entry has vector [7:0], level-sensitive [8] (1=level, 0=edge), active-low [9], mask [10], destination mode [12:11] and destination id [14:13]; the other bits read 0. Index 8 holds four 2-bit destination priority levels, with destination d at bits [2d+1:2d]. After reset the index is 0, every entry reads 32'h400 (masked) and the priority register reads 0.
- R2: An edge-sensitive line latches on each inactive-to-active transition of its polarity-adjusted input, and a single transition produces one message.
- R3: A level-sensitive line latches while its polarity-adjusted input is active, with active-low lines active when the pin is 0. The request is held even after the pin returns to inactive.
- R4: A line that has been delivered and acknowledged is not delivered again until an end-of-interrupt names it (`eoi_i` with `eoi_line_i`).
- R5: A masked line keeps its latch but issues no message. Clearing the mask of a line that is still pending causes a delivery.
- R6: When several lines are pending, the lowest index is sent first. No new message starts while one awaits acknowledge.
- R7: Destination mode 0 (and 3) sends to the entry's destination id.
- R8: Destination mode 1 sends to a round-robin pointer. The pointer starts at 0 and advances by one, wrapping after 3, on each accepted round-robin message.
- R9: Destination mode 2 sends to the destination with the lowest priority level in index 8. Ties go to the lowest destination number.
- R10: If an accepted message gets no acknowledge within 64 cycles, the same line, vector and destination are sent again, and this repeats without limit.
- R11: After end-of-interrupt, a level-sensitive line whose input is still active latches again at once and is delivered again.
- R12: While `msg_valid_o` is high and `msg_ready_i` is low, the valid, line, vector and destination outputs hold steady.
- R13: An acknowledge while waiting ends the delivery, and `msg_valid_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = index register, 1 = data register |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| msg_valid_o | output | 1 | Delivery message valid |
| msg_ready_i | input | 1 | Delivery message accepted |
| msg_line_o | output | 3 | Source line of the message |
| msg_vector_o | output | 8 | Vector carried by the message |
| msg_dest_o | output | 2 | Destination processor number |
| ack_i | input | 1 | Receiver acknowledge of the accepted message |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_line_i | input | 3 | Line released by end-of-interrupt |

## Verification
Several properties are checked on every cycle: message outputs stay steady while the handshake stalls, valid drops after an acknowledge, and a reissue comes exactly after the 64-cycle window with an unchanged line, vector and destination. Other behaviour is shown only by the bench scenarios. These cover the decoding of trigger mode and polarity, masking and unmasking, lowest-index ordering, round-robin sequencing, priority choice, holding until end-of-interrupt, and re-latching of a level line that is still active.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_DEST = 4;
  localparam int DEST_W   = 2;
  localparam int PRIO_W   = 2;
  localparam int VEC_W    = 8;
  localparam int DATA_W   = 32;

  typedef enum logic [1:0] {
    DM_FIXED = 2'd0,
    DM_RR    = 2'd1,
    DM_PRIO  = 2'd2,
    DM_ALT   = 2'd3
  } dest_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } dlv_state_e;

  // packed MSB first: dest_id[14:13] mode[12:11] mask[10] act_low[9] level[8] vector[7:0]
  typedef struct packed {
    logic [DEST_W-1:0] dest_id;
    dest_mode_e        mode;
    logic              mask;
    logic              act_low;
    logic              level;
    logic [VEC_W-1:0]  vector;
  } redir_t;

  localparam int ENTRY_W = $bits(redir_t);

  localparam redir_t REDIR_RST = '{
    dest_id: '0, mode: DM_FIXED, mask: 1'b1, act_low: 1'b0, level: 1'b0, vector: '0
  };
endpackage

// File: rtl/irq_line_latch.sv
module irq_line_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic level_i,
  input  logic act_low_i,
  input  logic eoi_i,
  output logic latched_o
);
  logic act, act_q, set;

  assign act = irq_i ^ act_low_i;
  assign set = level_i ? act : (act & ~act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      latched_o <= 1'b0;
    end else begin
      act_q     <= act;
      // a fresh request in the eoi cycle wins
      latched_o <= set | (latched_o & ~eoi_i);
    end
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES + 1),
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic                       sel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output redir_t [NUM_LINES-1:0]     entry_o,
  output logic [NUM_DEST*PRIO_W-1:0] prio_o
);
  localparam logic [IDX_W-1:0] PRIO_IDX = IDX_W'(NUM_LINES);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      prio_o <= '0;
      for (int i = 0; i < NUM_LINES; i++) entry_o[i] <= REDIR_RST;
    end else if (we_i) begin
      if (!sel_i) idx_q <= wdata_i[IDX_W-1:0];
      else if (idx_q == PRIO_IDX) prio_o <= wdata_i[NUM_DEST*PRIO_W-1:0];
      else if (idx_q < PRIO_IDX) entry_o[idx_q[LINE_W-1:0]] <= redir_t'(wdata_i[ENTRY_W-1:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!sel_i) rdata_o[IDX_W-1:0] = idx_q;
    else if (idx_q == PRIO_IDX) rdata_o[NUM_DEST*PRIO_W-1:0] = prio_o;
    else if (idx_q < PRIO_IDX) rdata_o[ENTRY_W-1:0] = entry_o[idx_q[LINE_W-1:0]];
  end
endmodule

// File: rtl/irq_dest_sel.sv
module irq_dest_sel
  import irq_router_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  dest_mode_e                 mode_i,
  input  logic [DEST_W-1:0]          fixed_i,
  input  logic [NUM_DEST*PRIO_W-1:0] prio_i,
  input  logic                       adv_i,
  output logic [DEST_W-1:0]          dest_o
);
  logic [DEST_W-1:0] rr_q, best_id;
  logic [PRIO_W-1:0] best_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (adv_i) rr_q <= (rr_q == DEST_W'(NUM_DEST - 1)) ? '0 : rr_q + 1'b1;
  end

  // descending scan with <= leaves the lowest index among equal levels
  always_comb begin
    best_lvl = '1;
    best_id  = '0;
    for (int d = NUM_DEST - 1; d >= 0; d--) begin
      if (prio_i[d*PRIO_W +: PRIO_W] <= best_lvl) begin
        best_lvl = prio_i[d*PRIO_W +: PRIO_W];
        best_id  = DEST_W'(d);
      end
    end
  end

  always_comb begin
    case (mode_i)
      DM_RR:   dest_o = rr_q;
      DM_PRIO: dest_o = best_id;
      default: dest_o = fixed_i;
    endcase
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter int RETRY_CYCLES = 64,
  parameter int LINE_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] cand_i,
  input  logic [NUM_LINES-1:0] eoi_vec_i,
  output logic [LINE_W-1:0]    pick_o,
  input  logic [VEC_W-1:0]     vec_i,
  input  logic [DEST_W-1:0]    dest_i,
  input  logic                 rr_i,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [LINE_W-1:0]    msg_line_o,
  output logic [VEC_W-1:0]     msg_vector_o,
  output logic [DEST_W-1:0]    msg_dest_o,
  input  logic                 ack_i,
  output logic                 rr_adv_o
);
  localparam int CNT_W = $clog2(RETRY_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_CYCLES - 1);

  dlv_state_e           state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_LINES-1:0] svc_q, pend, ack_set;
  logic                 rr_q;

  assign pend = cand_i & ~svc_q;

  always_comb begin
    pick_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) if (pend[i]) pick_o = LINE_W'(i);
  end

  assign ack_set     = (state_q == ST_WAIT && ack_i) ? (NUM_LINES'(1) << msg_line_o) : '0;
  assign msg_valid_o = (state_q == ST_SEND);
  assign rr_adv_o    = msg_valid_o & msg_ready_i & rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      svc_q        <= '0;
      rr_q         <= 1'b0;
      msg_line_o   <= '0;
      msg_vector_o <= '0;
      msg_dest_o   <= '0;
    end else begin
      svc_q <= (svc_q & ~eoi_vec_i) | ack_set;
      case (state_q)
        ST_IDLE: if (|pend) begin
          msg_line_o   <= pick_o;
          msg_vector_o <= vec_i;
          msg_dest_o   <= dest_i;
          rr_q         <= rr_i;
          state_q      <= ST_SEND;
        end
        ST_SEND: if (msg_ready_i) begin
          cnt_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ack_i) state_q <= ST_IDLE;
          else if (cnt_q == CNT_LAST) state_q <= ST_SEND;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter int RETRY_CYCLES = 64,
  parameter int LINE_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 reg_we_i,
  input  logic                 reg_sel_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [LINE_W-1:0]    msg_line_o,
  output logic [7:0]           msg_vector_o,
  output logic [1:0]           msg_dest_o,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  input  logic [LINE_W-1:0]    eoi_line_i
);
  redir_t [NUM_LINES-1:0]     entry;
  logic [NUM_DEST*PRIO_W-1:0] prio;
  logic [NUM_LINES-1:0]       latched, masked, eoi_vec;
  logic [LINE_W-1:0]          pick;
  logic [DEST_W-1:0]          dest;
  logic                       rr_adv;
  redir_t                     sel_entry;

  irq_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .entry_o (entry),
    .prio_o  (prio)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign masked[g]  = entry[g].mask;
    assign eoi_vec[g] = eoi_i && (eoi_line_i == LINE_W'(g));
    irq_line_latch u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (irq_i[g]),
      .level_i   (entry[g].level),
      .act_low_i (entry[g].act_low),
      .eoi_i     (eoi_vec[g]),
      .latched_o (latched[g])
    );
  end

  assign sel_entry = entry[pick];

  irq_dest_sel u_dest (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (sel_entry.mode),
    .fixed_i (sel_entry.dest_id),
    .prio_i  (prio),
    .adv_i   (rr_adv),
    .dest_o  (dest)
  );

  irq_dispatch #(.NUM_LINES(NUM_LINES), .RETRY_CYCLES(RETRY_CYCLES)) u_disp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cand_i       (latched & ~masked),
    .eoi_vec_i    (eoi_vec),
    .pick_o       (pick),
    .vec_i        (sel_entry.vector),
    .dest_i       (dest),
    .rr_i         (sel_entry.mode == DM_RR),
    .msg_valid_o  (msg_valid_o),
    .msg_ready_i  (msg_ready_i),
    .msg_line_o   (msg_line_o),
    .msg_vector_o (msg_vector_o),
    .msg_dest_o   (msg_dest_o),
    .ack_i        (ack_i),
    .rr_adv_o     (rr_adv)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_LINES    = 8,
  parameter int RETRY_CYCLES = 64,
  parameter int LINE_W       = $clog2(NUM_LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [LINE_W-1:0] msg_line_o,
  input logic [7:0]        msg_vector_o,
  input logic [1:0]        msg_dest_o,
  input logic              ack_i
);
  localparam int CW = $clog2(RETRY_CYCLES) + 2;

  logic              out_q;
  logic [CW-1:0]     wait_q;
  logic [LINE_W-1:0] line_q;
  logic [7:0]        vec_q;
  logic [1:0]        dest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0; wait_q <= '0; line_q <= '0; vec_q <= '0; dest_q <= '0;
    end else if (msg_valid_o && msg_ready_i) begin
      out_q <= 1'b1; wait_q <= '0;
      line_q <= msg_line_o; vec_q <= msg_vector_o; dest_q <= msg_dest_o;
    end else if (out_q && !msg_valid_o) begin
      if (ack_i) out_q <= 1'b0;
      else wait_q <= wait_q + 1'b1;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_line_o)
      && $stable(msg_vector_o) && $stable(msg_dest_o)); // R12

  AST_ACK_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q && !msg_valid_o && ack_i |=> !msg_valid_o); // R13

  AST_RETRY_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) && out_q |-> wait_q == CW'(RETRY_CYCLES)); // R10

  AST_RETRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q && !msg_valid_o |-> wait_q < CW'(RETRY_CYCLES)); // R10

  AST_RETRY_SAME_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) && out_q |-> msg_line_o == line_q && msg_vector_o == vec_q
      && msg_dest_o == dest_q); // R10
endmodule

bind irq_router irq_router_chk #(.NUM_LINES(NUM_LINES), .RETRY_CYCLES(RETRY_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .msg_valid_o  (msg_valid_o),
  .msg_ready_i  (msg_ready_i),
  .msg_line_o   (msg_line_o),
  .msg_vector_o (msg_vector_o),
  .msg_dest_o   (msg_dest_o),
  .ack_i        (ack_i)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq = '0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [2:0]  msg_line;
  logic [7:0]  msg_vector;
  logic [1:0]  msg_dest;
  logic        ack = 1'b0, eoi = 1'b0;
  logic [2:0]  eoi_line = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_line_o(msg_line),
    .msg_vector_o(msg_vector), .msg_dest_o(msg_dest),
    .ack_i(ack), .eoi_i(eoi), .eoi_line_i(eoi_line)
  );

  // row: line[18:16] level[15] act_low[14] mode[13:12] id[11:10] vector[9:2] expected dest[1:0]
  localparam logic [18:0] ROWS [8] = '{
    {3'd2, 1'b0, 1'b0, 2'd0, 2'd3, 8'h41, 2'd3},
    {3'd5, 1'b1, 1'b1, 2'd0, 2'd1, 8'h52, 2'd1},
    {3'd0, 1'b0, 1'b0, 2'd1, 2'd0, 8'h20, 2'd0},
    {3'd7, 1'b1, 1'b0, 2'd1, 2'd0, 8'h27, 2'd1},
    {3'd3, 1'b0, 1'b1, 2'd1, 2'd0, 8'h33, 2'd2},
    {3'd1, 1'b1, 1'b0, 2'd2, 2'd0, 8'h11, 2'd0},
    {3'd6, 1'b0, 1'b0, 2'd3, 2'd2, 8'h66, 2'd2},
    {3'd2, 1'b1, 1'b0, 2'd1, 2'd0, 8'h72, 2'd3}
  };

  function automatic logic [31:0] mk(input logic [1:0] id, input logic [1:0] mode,
                                     input logic mask, input logic low, input logic lvl,
                                     input logic [7:0] vec);
    return {17'b0, id, mode, mask, low, lvl, vec};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic set_entry(input int line, input logic [31:0] e);
    reg_wr(1'b0, 32'(line)); reg_wr(1'b1, e);
  endtask

  task automatic wait_msg(input int n, output bit got);
    got = 1'b0;
    for (int i = 0; i < n && !got; i++) begin
      @(negedge clk);
      if (msg_valid) got = 1'b1;
    end
  endtask

  task automatic quiet(input int n, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid) ok = 1'b0;
    end
  endtask

  task automatic accept();
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_eoi(input int line);
    eoi = 1'b1; eoi_line = 3'(line); @(negedge clk); eoi = 1'b0;
  endtask

  // program masked, settle the pin inactive, clear any stray latch, then unmask
  task automatic prep(input int line, input logic [31:0] e, input logic low);
    set_entry(line, e | 32'h400);
    irq[line] = low;
    repeat (2) @(negedge clk);
    do_eoi(line);
    set_entry(line, e & ~32'h400);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    bit got, ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R1
    @(negedge clk);
    chk(!msg_valid, "R1 reset valid", 32'(msg_valid), 0);
    reg_rd(1'b0, rd); chk(rd == 0, "R1 reset index", rd, 0);
    reg_rd(1'b1, rd); chk(rd == 32'h400, "R1 reset entry", rd, 32'h400);
    reg_wr(1'b0, 32'd8);
    reg_rd(1'b1, rd); chk(rd == 0, "R1 reset prio", rd, 0);
    set_entry(3, 32'hFFFF_FFFF);
    reg_rd(1'b1, rd); chk(rd == 32'h7FFF, "R1 entry readback", rd, 32'h7FFF);
    reg_rd(1'b0, rd); chk(rd == 3, "R1 index readback", rd, 3);
    set_entry(3, 32'h400);

    // vector table
    for (int r = 0; r < 8; r++) begin
      logic [2:0] ln; logic lvl, low; logic [1:0] mode, id, exp; logic [7:0] vec;
      string tag;
      {ln, lvl, low, mode, id, vec, exp} = ROWS[r];
      tag = (mode == 2'd1) ? "R8" : (mode == 2'd2) ? "R9" : "R7";
      prep(ln, mk(id, mode, 1'b0, low, lvl, vec), low);
      irq[ln] = ~low;
      wait_msg(10, got);
      chk(got, lvl ? "R3 level delivery" : "R2 edge delivery", 32'(got), 1);
      chk(msg_line == ln && msg_vector == vec, lvl ? "R3 line/vector" : "R2 line/vector",
          {msg_line, msg_vector}, {ln, vec});
      chk(msg_dest == exp, tag, 32'(msg_dest), 32'(exp));
      accept();
      do_ack();
      irq[ln] = low;
      repeat (2) @(negedge clk);
      do_eoi(ln);
      set_entry(ln, mk(id, mode, 1'b1, low, lvl, vec));
    end

    // R4 short level pulse held; no redelivery before eoi
    prep(4, mk(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h44), 1'b0);
    irq[4] = 1'b1; @(negedge clk); irq[4] = 1'b0;
    wait_msg(10, got);
    chk(got && msg_line == 4, "R4 held pulse delivered", {31'b0, got}, 1);
    accept(); do_ack();
    quiet(10, ok); chk(ok, "R4 no resend before eoi", 32'(ok), 1);
    do_eoi(4);
    quiet(10, ok); chk(ok, "R4 released by eoi", 32'(ok), 1);

    // R11 level still active at eoi
    irq[4] = 1'b1;
    wait_msg(10, got); chk(got, "R11 first delivery", 32'(got), 1);
    accept(); do_ack();
    do_eoi(4);
    wait_msg(10, got);
    chk(got && msg_line == 4, "R11 relatched after eoi", {31'b0, got}, 1);
    accept(); do_ack();
    irq[4] = 1'b0; @(negedge clk); do_eoi(4);
    set_entry(4, 32'h400);

    // R5 masked line keeps latch; unmask delivers
    irq[5] = 1'b0;
    quiet(10, ok); chk(ok, "R5 masked silent", 32'(ok), 1);
    set_entry(5, mk(2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 8'h52));
    wait_msg(10, got);
    chk(got && msg_line == 5, "R5 unmask delivers", {29'b0, msg_line}, 5);
    accept(); do_ack();
    irq[5] = 1'b1; @(negedge clk); do_eoi(5);
    set_entry(5, mk(2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 8'h52));

    // R6 ordering and single message in flight
    prep(0, mk(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA0), 1'b0);
    prep(6, mk(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA6), 1'b0);
    irq[0] = 1'b1; irq[6] = 1'b1;
    wait_msg(10, got);
    chk(got && msg_line == 0, "R6 lowest first", {29'b0, msg_line}, 0);
    accept();
    quiet(5, ok); chk(ok, "R6 one in flight", 32'(ok), 1);
    do_ack();
    wait_msg(10, got);
    chk(got && msg_line == 6, "R6 next line", {29'b0, msg_line}, 6);
    accept(); do_ack();
    irq[0] = 1'b0; irq[6] = 1'b0;
    do_eoi(0); do_eoi(6);
    set_entry(0, 32'h400); set_entry(6, 32'h400);

    // R10 retry, R12 stall hold, R13 ack ends
    prep(1, mk(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h99), 1'b0);
    irq[1] = 1'b1;
    wait_msg(10, got); chk(got, "R10 first send", 32'(got), 1);
    accept();
    quiet(60, ok); chk(ok, "R10 no early resend", 32'(ok), 1);
    wait_msg(10, got);
    chk(got && msg_line == 1 && msg_vector == 8'h99 && msg_dest == 1, "R10 resend same msg",
        {msg_line, msg_vector, msg_dest}, {3'd1, 8'h99, 2'd1});
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_vector == 8'h99, "R12 held while stalled", {msg_valid, msg_vector}, {1'b1, 8'h99});
    accept(); do_ack();
    chk(!msg_valid, "R13 valid low after ack", 32'(msg_valid), 0);
    irq[1] = 1'b0; do_eoi(1);
    set_entry(1, 32'h400);

    // R9 priority with distinct levels: dest2 lowest
    reg_wr(1'b0, 32'd8); reg_wr(1'b1, 32'h9B);
    reg_rd(1'b1, rd); chk(rd == 32'h9B, "R1 prio readback", rd, 32'h9B);
    prep(7, mk(2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 8'h77), 1'b0);
    irq[7] = 1'b1;
    wait_msg(10, got);
    chk(got && msg_dest == 2, "R9 lowest level wins", {30'b0, msg_dest}, 2);
    accept(); do_ack();
    irq[7] = 1'b0; @(negedge clk); do_eoi(7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule